// File: doc/BRIEF.md
# Burst-of-two split-port SRAM

A synchronous pipelined memory with one port that only reads and one port that only writes. The two ports share one multiplexed address input. Every access moves two bus-width words, lower half first, and both words belong to a single internal entry that is twice the bus width. The block runs on a beat clock at twice the command rate. The input `phase_i` is high on the first-phase beat of each command period and low on the second-phase beat. A read and a write may both start in the same period.

A read is taken from the address on the first-phase edge. Its two data beats leave the block in the following period. A write is taken on the same first-phase edge, but its address is sampled on the second-phase edge of that period. Its two data beats arrive in the following period. Per-lane byte enables qualify each write beat on its own. A read that hits a write accepted in the same period returns the new bytes.

Top module: `b2s_sram`

## Requirements
- R1: A read and a write commanded in the same period both complete. The read data port and the write data port are independent.
- R2: A read taken on the first-phase edge of period p drives bits [DW-1:0] of the entry on `rdata_o` after the first-phase edge of period p+1. It drives bits [2*DW-1:DW] after the second-phase edge of period p+1.
- R3: The read address is `addr_i` sampled on the first-phase edge where `rd_ni` is low. The value of `addr_i` on second-phase edges has no effect on a read.
- R4: The write address is `addr_i` sampled on the second-phase edge of the period in which `wr_ni` was low on the first-phase edge. The lower write beat is taken from `wdata_i` on the next first-phase edge and the upper beat on the next second-phase edge. The entry is updated at that second-phase edge.
- R5: Byte lane k is bits [k*BYTE_W +: BYTE_W] of a beat. `bw_ni[k]` low on a write beat stores lane k of that beat into the matching half of the entry. `bw_ni[k]` high leaves that stored byte unchanged.
- R6: Selects are active low. `rd_ni` high on a first-phase edge starts no read. `wr_ni` high starts no write, and the data and byte enables then driven change no entry.
- R7: When no read burst is being output, `rdata_o` is zero and `rvalid_o` is low. `rvalid_o` is high for exactly the two beats of each read burst.
- R8: A read taken in the same period as a write to the same address returns the newly written bytes in enabled lanes and the previously stored bytes in the other lanes.
- R9: Asynchronous reset clears `rvalid_o` and `rdata_o` and discards a write whose data has not been committed.
- R10: Reads and writes may be issued in every consecutive period, giving a continuous stream of read beats.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Beat clock, two beats per command period |
| rst_ni | input | 1 | Asynchronous active-low reset |
| phase_i | input | 1 | High on the first-phase beat of a period |
| addr_i | input | AW | Shared read/write address |
| rd_ni | input | 1 | Read select, active low |
| wr_ni | input | 1 | Write select, active low |
| bw_ni | input | DW/BYTE_W | Per-lane write enables, active low, per beat |
| wdata_i | input | DW | Write data beat |
| rdata_o | output | DW | Read data beat |
| rvalid_o | output | 1 | High during the two beats of a read burst |

## Verification
The bench issues a read and a write to the same address in the same period, with only some lanes enabled. A design without forwarding returns the old word. A design that forwards whole beats returns the new data in the disabled lanes. One period drives different addresses on the two phases. A design that samples the write address on the wrong phase corrupts the read-address entry, and a later read of that entry shows it. An idle period carries live data and zero byte enables, which exposes a design that ignores the write select. A write is aborted by reset between its address and data phases, and the bench then confirms the entry is unchanged.

// File: rtl/b2s_pkg.sv
package b2s_pkg;
  typedef enum logic {
    BEAT_SECOND = 1'b0,
    BEAT_FIRST  = 1'b1
  } beat_e;
endpackage

// File: rtl/b2s_cmd.sv
module b2s_cmd
  import b2s_pkg::*;
#(
  parameter int unsigned AW = 6
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          phase_i,
  input  logic          rd_ni,
  input  logic          wr_ni,
  input  logic [AW-1:0] addr_i,
  output logic          launch_o,
  output logic          fwd_o,
  output logic [AW-1:0] rd_addr_o,
  output logic          wlat_o,
  output logic          commit_o,
  output logic [AW-1:0] waddr_o
);
  beat_e         beat;
  logic          rd_pend_q, wr_pend_q, wc_v_q;
  logic [AW-1:0] rd_addr_q, wa_q, wc_addr_q;

  assign beat      = beat_e'(phase_i);
  assign launch_o  = (beat == BEAT_FIRST) && rd_pend_q;
  assign fwd_o     = rd_pend_q && wr_pend_q && (rd_addr_q == wa_q);
  assign wlat_o    = (beat == BEAT_FIRST) && wr_pend_q;
  assign commit_o  = (beat == BEAT_SECOND) && wc_v_q;
  assign rd_addr_o = rd_addr_q;
  assign waddr_o   = wc_addr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_pend_q <= 1'b0;
      wr_pend_q <= 1'b0;
      wc_v_q    <= 1'b0;
      rd_addr_q <= '0;
      wa_q      <= '0;
      wc_addr_q <= '0;
    end else if (beat == BEAT_FIRST) begin
      rd_pend_q <= !rd_ni;
      if (!rd_ni) rd_addr_q <= addr_i;
      wr_pend_q <= !wr_ni;
      wc_v_q    <= wr_pend_q;
      wc_addr_q <= wa_q;
    end else begin
      if (wr_pend_q) wa_q <= addr_i;
      wc_v_q <= 1'b0;
    end
  end

  // commit stage only ever spans a second-phase beat
  p_commit_on_b_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wc_v_q |-> !phase_i);
endmodule

// File: rtl/b2s_wpath.sv
module b2s_wpath #(
  parameter int unsigned DW     = 18,
  parameter int unsigned BYTE_W = 9,
  localparam int unsigned NB    = DW / BYTE_W
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            wlat_i,
  input  logic            commit_i,
  input  logic [DW-1:0]   wdata_i,
  input  logic [NB-1:0]   bw_ni,
  output logic [2*NB-1:0] we_o,
  output logic [2*DW-1:0] wword_o
);
  logic [DW-1:0] lo_q;
  logic [NB-1:0] bwlo_n_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_q     <= '0;
      bwlo_n_q <= '1;
    end else if (wlat_i) begin
      lo_q     <= wdata_i;
      bwlo_n_q <= bw_ni;
    end
  end

  assign we_o    = commit_i ? {~bw_ni, ~bwlo_n_q} : '0;
  assign wword_o = {wdata_i, lo_q};

  p_we_only_commit_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_o != '0) |-> !wlat_i);
endmodule

// File: rtl/b2s_mem.sv
module b2s_mem #(
  parameter int unsigned AW     = 6,
  parameter int unsigned WW     = 36,
  parameter int unsigned BYTE_W = 9,
  localparam int unsigned NL    = WW / BYTE_W,
  localparam int unsigned DEPTH = 1 << AW
) (
  input  logic          clk_i,
  input  logic [NL-1:0] we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [WW-1:0] wword_i,
  input  logic [AW-1:0] raddr_i,
  output logic [WW-1:0] rword_o
);
  logic [WW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    for (int k = 0; k < int'(NL); k++) begin
      if (we_i[k]) mem_q[waddr_i][k*BYTE_W +: BYTE_W] <= wword_i[k*BYTE_W +: BYTE_W];
    end
  end

  assign rword_o = mem_q[raddr_i];
endmodule

// File: rtl/b2s_rpath.sv
module b2s_rpath
  import b2s_pkg::*;
#(
  parameter int unsigned DW     = 18,
  parameter int unsigned BYTE_W = 9,
  localparam int unsigned NB    = DW / BYTE_W
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            phase_i,
  input  logic            launch_i,
  input  logic            fwd_i,
  input  logic [2*DW-1:0] mem_word_i,
  input  logic [DW-1:0]   wdata_i,
  input  logic [NB-1:0]   bw_ni,
  output logic [DW-1:0]   rdata_o,
  output logic            rvalid_o
);
  beat_e         beat;
  logic [DW-1:0] lo_mix, hi_mix, hold_hi_q;
  logic          lo_beat_q, fwd_q;

  assign beat = beat_e'(phase_i);

  // same-period write bypass, lane by lane
  for (genvar k = 0; k < int'(NB); k++) begin : g_lane
    assign lo_mix[k*BYTE_W +: BYTE_W] = (fwd_i && !bw_ni[k]) ?
      wdata_i[k*BYTE_W +: BYTE_W] : mem_word_i[k*BYTE_W +: BYTE_W];
    assign hi_mix[k*BYTE_W +: BYTE_W] = (fwd_q && !bw_ni[k]) ?
      wdata_i[k*BYTE_W +: BYTE_W] : hold_hi_q[k*BYTE_W +: BYTE_W];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_o   <= '0;
      rvalid_o  <= 1'b0;
      hold_hi_q <= '0;
      lo_beat_q <= 1'b0;
      fwd_q     <= 1'b0;
    end else if (beat == BEAT_FIRST) begin
      if (launch_i) begin
        rdata_o   <= lo_mix;
        rvalid_o  <= 1'b1;
        hold_hi_q <= mem_word_i[2*DW-1:DW];
        lo_beat_q <= 1'b1;
        fwd_q     <= fwd_i;
      end else begin
        rdata_o   <= '0;
        rvalid_o  <= 1'b0;
        lo_beat_q <= 1'b0;
        fwd_q     <= 1'b0;
      end
    end else if (lo_beat_q) begin
      rdata_o   <= hi_mix;
      lo_beat_q <= 1'b0;
    end else begin
      rdata_o  <= '0;
      rvalid_o <= 1'b0;
    end
  end

  p_idle_zero_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rvalid_o |-> (rdata_o == '0));
  p_two_beats_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rvalid_o && lo_beat_q) |=> (rvalid_o && !lo_beat_q));
  p_lo_after_first_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rvalid_o) |-> !phase_i);
endmodule

// File: rtl/b2s_sram.sv
module b2s_sram #(
  parameter int unsigned AW     = 6,
  parameter int unsigned DW     = 18,
  parameter int unsigned BYTE_W = 9,
  localparam int unsigned NB    = DW / BYTE_W,
  localparam int unsigned WW    = 2 * DW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          phase_i,
  input  logic [AW-1:0] addr_i,
  input  logic          rd_ni,
  input  logic          wr_ni,
  input  logic [NB-1:0] bw_ni,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  output logic          rvalid_o
);
  logic            launch, fwd, wlat, commit;
  logic [AW-1:0]   rd_addr, waddr;
  logic [2*NB-1:0] we;
  logic [WW-1:0]   wword, rword;

  b2s_cmd #(.AW(AW)) u_cmd (
    .clk_i, .rst_ni, .phase_i, .rd_ni, .wr_ni, .addr_i,
    .launch_o(launch), .fwd_o(fwd), .rd_addr_o(rd_addr),
    .wlat_o(wlat), .commit_o(commit), .waddr_o(waddr)
  );

  b2s_wpath #(.DW(DW), .BYTE_W(BYTE_W)) u_wpath (
    .clk_i, .rst_ni, .wlat_i(wlat), .commit_i(commit),
    .wdata_i, .bw_ni, .we_o(we), .wword_o(wword)
  );

  b2s_mem #(.AW(AW), .WW(WW), .BYTE_W(BYTE_W)) u_mem (
    .clk_i, .we_i(we), .waddr_i(waddr), .wword_i(wword),
    .raddr_i(rd_addr), .rword_o(rword)
  );

  b2s_rpath #(.DW(DW), .BYTE_W(BYTE_W)) u_rpath (
    .clk_i, .rst_ni, .phase_i, .launch_i(launch), .fwd_i(fwd),
    .mem_word_i(rword), .wdata_i, .bw_ni, .rdata_o, .rvalid_o
  );
endmodule

// File: tb/b2s_sram_tb.sv
module b2s_sram_tb;
  localparam int CLK_P = 10;
  localparam int AW = 6, DW = 18, BW = 9, NB = 2, N = 11;

  typedef struct packed {
    logic          rd;
    logic [AW-1:0] ra;
    logic          wr;
    logic [AW-1:0] wa;
    logic [DW-1:0] lo;
    logic [DW-1:0] hi;
    logic [NB-1:0] bwl;
    logic [NB-1:0] bwh;
    logic [2:0]    code;
  } vec_t;

  // rd ra wr wa lo hi bwl bwh code
  localparam vec_t VEC [N] = '{
    '{1'b0, 6'd0,  1'b1, 6'd5,  18'h12345, 18'h0ABCD, 2'b00, 2'b00, 3'd0},
    '{1'b1, 6'd5,  1'b1, 6'd9,  18'h3FFFF, 18'h00001, 2'b00, 2'b00, 3'd0},
    '{1'b1, 6'd5,  1'b1, 6'd5,  18'h11111, 18'h22222, 2'b10, 2'b01, 3'd1},
    '{1'b1, 6'd9,  1'b1, 6'd9,  18'h00000, 18'h00000, 2'b11, 2'b11, 3'd2},
    '{1'b1, 6'd5,  1'b0, 6'd0,  18'h00000, 18'h00000, 2'b00, 2'b00, 3'd2},
    '{1'b0, 6'd5,  1'b0, 6'd5,  18'h00000, 18'h00000, 2'b00, 2'b00, 3'd3},
    '{1'b1, 6'd5,  1'b1, 6'd7,  18'h2A5A5, 18'h15A5A, 2'b00, 2'b00, 3'd3},
    '{1'b1, 6'd7,  1'b1, 6'd12, 18'h00F0F, 18'h3C3C3, 2'b00, 2'b00, 3'd5},
    '{1'b1, 6'd12, 1'b1, 6'd7,  18'h1E1E1, 18'h07070, 2'b00, 2'b00, 3'd5},
    '{1'b1, 6'd7,  1'b0, 6'd0,  18'h00000, 18'h00000, 2'b00, 2'b00, 3'd4},
    '{1'b1, 6'd12, 1'b0, 6'd0,  18'h00000, 18'h00000, 2'b00, 2'b00, 3'd4}
  };

  logic          clk_i = 1'b0, rst_ni = 1'b0, phase_i = 1'b0;
  logic [AW-1:0] addr_i = '0;
  logic          rd_ni = 1'b1, wr_ni = 1'b1;
  logic [NB-1:0] bw_ni = '1;
  logic [DW-1:0] wdata_i = '0;
  logic [DW-1:0] rdata_o;
  logic          rvalid_o;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  logic [2*DW-1:0] model [1<<AW];
  vec_t  prev;
  bit    r1_v, r2_v;
  logic [DW-1:0] r1_lo, r1_hi, r2_hi;
  string r1_tag, r2_tag;

  b2s_sram u_dut (.*);

  always #(CLK_P/2) clk_i = ~clk_i;

  function automatic string tag_of(input logic [2:0] c);
    case (c)
      3'd1:    return "R8 R1 same-period forward";
      3'd2:    return "R5 byte lanes";
      3'd3:    return "R6 ignored select";
      3'd4:    return "R4 write address phase";
      3'd5:    return "R10 back-to-back";
      default: return "R2 R3 read";
    endcase
  endfunction

  task automatic chk(input bit ok, input string what, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", what, act, exp);
    end
  endtask

  task automatic check_beat(input bit v, input logic [DW-1:0] d, input string tag);
    if (v) begin
      chk(rvalid_o === 1'b1, {tag, " R7 valid"}, DW'(rvalid_o), DW'(1));
      chk(rdata_o === d, {tag, " data"}, rdata_o, d);
    end else begin
      chk(rvalid_o === 1'b0 && rdata_o === '0, "R7 idle output", rdata_o, '0);
    end
  endtask

  task automatic do_period(input vec_t v);
    logic [2*DW-1:0] w;
    @(negedge clk_i);
    check_beat(r2_v, r2_hi, {r2_tag, " upper"});
    phase_i = 1'b1; addr_i = v.ra; rd_ni = !v.rd; wr_ni = !v.wr;
    wdata_i = prev.wr ? prev.lo : 18'h3FFFF;
    bw_ni   = prev.wr ? prev.bwl : '0;
    if (v.wr) begin
      w = model[v.wa];
      for (int k = 0; k < NB; k++) begin
        if (!v.bwl[k]) w[k*BW +: BW] = v.lo[k*BW +: BW];
        if (!v.bwh[k]) w[DW + k*BW +: BW] = v.hi[k*BW +: BW];
      end
      model[v.wa] = w;
    end
    @(negedge clk_i);
    check_beat(r1_v, r1_lo, {r1_tag, " lower"});
    phase_i = 1'b0; addr_i = v.wa;
    wdata_i = prev.wr ? prev.hi : 18'h2AAAA;
    bw_ni   = prev.wr ? prev.bwh : '0;
    r2_v = r1_v; r2_hi = r1_hi; r2_tag = r1_tag;
    r1_v = v.rd;
    r1_lo = model[v.ra][DW-1:0];
    r1_hi = model[v.ra][2*DW-1:DW];
    r1_tag = tag_of(v.code);
    prev = v;
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    vec_t idle, w5;
    logic [2*DW-1:0] keep;
    idle = '0;
    prev = '0;
    r1_v = 0; r2_v = 0; r1_tag = ""; r2_tag = "";
    for (int i = 0; i < (1 << AW); i++) model[i] = '0;
    repeat (3) @(negedge clk_i);
    chk(rvalid_o === 1'b0 && rdata_o === '0, "R9 reset state", rdata_o, '0);
    rst_ni = 1'b1;

    for (int i = 0; i < N; i++) do_period(VEC[i]);
    do_period(idle);
    do_period(idle);

    // R9: write aborted by reset between address and data phases
    w5 = '0; w5.wr = 1'b1; w5.wa = 6'd5; w5.lo = 18'h0F0F0; w5.hi = 18'h30303;
    keep = model[5];
    do_period(w5);
    @(negedge clk_i);
    rst_ni = 1'b0;
    model[5] = keep;
    prev = '0; r1_v = 0; r2_v = 0;
    #1;
    chk(rvalid_o === 1'b0 && rdata_o === '0, "R9 reset clears output", rdata_o, '0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    do_period(idle);
    w5 = '0; w5.rd = 1'b1; w5.ra = 6'd5;
    do_period(w5);
    r1_tag = "R9 aborted write";
    do_period(idle);
    do_period(idle);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule